// File: doc/BRIEF.md
# Dual-Modulus Pulse-Swallow Frequency Divider

This block divides a fast input clock by a programmable integer, using a prescaler that counts either 10 or 11 input cycles, followed by a swallow counter and a main counter. Each main cycle is made of M+1 prescaler cycles. The swallow counter keeps the prescaler at its longer modulus for the first A of those cycles, which gives a total ratio of 10·(M+1)+A. The output is one pulse per main cycle, and it is meant to feed a phase comparator.

A bypass control makes every input clock a prescaler cycle, so the ratio becomes M+1. A narrow-programming flag clears the two upper bits of M, which limits M to 1..127. The modulus-select line and the prescaler's end-of-cycle strobe are brought out for monitoring. The block latches all control values only when a main cycle ends, so no main cycle is ever divided by a mix of two settings.

Top module: `pswallow_div`

## Requirements
- R1: With `presc_en_n`=0 and A ≤ M+1, consecutive `div_pulse` rising edges are exactly 10·(M+1)+A input clocks apart.
- R2: With `presc_en_n`=1, the pulse period is M+1 input clocks and `a_val` has no effect. M=1 gives the minimum period of 2.
- R3: With `direct_mode`=1, bits 8 and 7 of `m_val` are treated as zero, so the effective M is `m_val[6:0]`. This applies in both prescaler modes.
- R4: `msel_mon`=1 selects divide-by-11. Within each main cycle it is high for the first A prescaler cycles (11·A input clocks) and low for the rest. It is always low in bypass.
- R5: `div_pulse` is high for exactly one input clock per main cycle.
- R6: `m_val`, `a_val`, `presc_en_n` and `direct_mode` are sampled only in the clock edge that ends a main cycle, which is the edge that raises `div_pulse`. Changes at any other time have no effect on the main cycle in progress.
- R7: `presc_mon` is high for one clock at the last input clock of every prescaler cycle, so there are M+1 strobes per main cycle. In bypass it is high on every clock.
- R8: While `rst_n` is low, `div_pulse`, `msel_mon` and `presc_mon` are all low.
- R9: The edge values A=0 (every prescaler cycle divides by 10) and A=M+1 (every prescaler cycle divides by 11) follow the R1 ratio.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast input clock to be divided |
| rst_n | input | 1 | Asynchronous active-low reset |
| m_val | input | 9 | Main counter value M (1..511) |
| a_val | input | 4 | Swallow count A (0..15, at most M+1) |
| presc_en_n | input | 1 | 0 = prescaler active, 1 = bypass |
| direct_mode | input | 1 | 1 = clear M bits 8:7 |
| div_pulse | output | 1 | One-clock pulse per main cycle |
| msel_mon | output | 1 | Modulus select monitor (1 = divide by 11) |
| presc_mon | output | 1 | Prescaler end-of-cycle strobe |

## Verification
Three things can happen on the same edge: the last prescaler strobe of a main cycle, the end of the swallow phase, and the reload of new settings. When A=M+1, the swallow counter expires on the final prescaler cycle, which is the same edge that reloads it. The bench drives that case and checks the period and the count of `msel_mon`-high clocks over a full cycle. The bench also changes the settings in the clock right after a pulse, and briefly mid-cycle. The main cycle in flight must keep the old ratio, and the following cycle must show the new one.

// File: rtl/pswallow_pkg.sv
package pswallow_pkg;
    localparam int unsigned DEF_M_W        = 9;
    localparam int unsigned DEF_A_W        = 4;
    localparam int unsigned DEF_NARROW_M_W = 7;
    localparam int unsigned DEF_BASE_MOD   = 10;
endpackage

// File: rtl/pswallow_prescaler.sv
module pswallow_prescaler
    import pswallow_pkg::*;
#(
    parameter int unsigned BASE_MOD = DEF_BASE_MOD
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bypass_i,
    input  logic msel_i,
    output logic tick_o
);
    localparam int unsigned CNT_W = $clog2(BASE_MOD + 1);
    localparam logic [CNT_W-1:0] TERM_LO = CNT_W'(BASE_MOD - 1);
    localparam logic [CNT_W-1:0] TERM_HI = CNT_W'(BASE_MOD);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } pre_state_t;

    pre_state_t st_d, st_q;
    logic [CNT_W-1:0] term;
    logic tick;

    always_comb begin
        term = msel_i ? TERM_HI : TERM_LO;
        tick = bypass_i || (st_q.cnt == term);
        st_d = st_q;
        if (tick) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tick_o = tick;

    // R7
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= TERM_HI);

    // R4
    long_mod_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt == TERM_HI) |-> msel_i);

    // R7
    bypass_idle_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bypass_i |-> (st_q.cnt == '0));
endmodule

// File: rtl/pswallow_ctrl.sv
module pswallow_ctrl
    import pswallow_pkg::*;
#(
    parameter int unsigned M_W = DEF_M_W,
    parameter int unsigned A_W = DEF_A_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           tick_i,
    input  logic [M_W-1:0] m_i,
    input  logic [A_W-1:0] a_i,
    input  logic           bypass_req_i,
    output logic           msel_o,
    output logic           bypass_o,
    output logic           pulse_o
);
    typedef struct packed {
        logic [M_W-1:0] m_left;
        logic [A_W-1:0] a_left;
        logic           bypass;
        logic           pulse;
    } ctrl_state_t;

    ctrl_state_t st_d, st_q;
    logic last_pre;

    always_comb begin
        last_pre = tick_i && (st_q.m_left == '0);
        st_d = st_q;
        st_d.pulse = last_pre;
        if (tick_i) begin
            if (last_pre) begin
                st_d.m_left = m_i;
                st_d.a_left = bypass_req_i ? '0 : a_i;
                st_d.bypass = bypass_req_i;
            end else begin
                st_d.m_left = st_q.m_left - 1'b1;
                if (st_q.a_left != '0) begin
                    st_d.a_left = st_q.a_left - 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign msel_o   = (st_q.a_left != '0) && !st_q.bypass;
    assign bypass_o = st_q.bypass;
    assign pulse_o  = st_q.pulse;

    // R4
    swallow_idle_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.bypass |-> (st_q.a_left == '0));

    // R6
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(tick_i && (st_q.m_left == '0)) |=> $stable(st_q.bypass));

    // R4
    msel_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> $stable(msel_o));

    // R5
    pulse_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_o |-> $past(tick_i));
endmodule

// File: rtl/pswallow_div.sv
module pswallow_div
    import pswallow_pkg::*;
#(
    parameter int unsigned M_W        = DEF_M_W,
    parameter int unsigned A_W        = DEF_A_W,
    parameter int unsigned NARROW_M_W = DEF_NARROW_M_W,
    parameter int unsigned BASE_MOD   = DEF_BASE_MOD
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [M_W-1:0] m_val,
    input  logic [A_W-1:0] a_val,
    input  logic           presc_en_n,
    input  logic           direct_mode,
    output logic           div_pulse,
    output logic           msel_mon,
    output logic           presc_mon
);
    logic [M_W-1:0] m_eff;
    logic           tick_w;
    logic           msel_w;
    logic           bypass_w;
    logic           pulse_w;

    generate
        if (M_W > NARROW_M_W) begin : g_narrow
            assign m_eff = direct_mode
                ? {{(M_W - NARROW_M_W){1'b0}}, m_val[NARROW_M_W-1:0]}
                : m_val;
        end else begin : g_full
            assign m_eff = m_val;
        end
    endgenerate

    pswallow_prescaler #(
        .BASE_MOD (BASE_MOD)
    ) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .bypass_i (bypass_w),
        .msel_i   (msel_w),
        .tick_o   (tick_w)
    );

    pswallow_ctrl #(
        .M_W (M_W),
        .A_W (A_W)
    ) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick_i       (tick_w),
        .m_i          (m_eff),
        .a_i          (a_val),
        .bypass_req_i (presc_en_n),
        .msel_o       (msel_w),
        .bypass_o     (bypass_w),
        .pulse_o      (pulse_w)
    );

    assign div_pulse = pulse_w;
    assign msel_mon  = msel_w;
    assign presc_mon = tick_w;

    // R5
    pulse_isolated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (div_pulse && !bypass_w) |=> !div_pulse);

    // R4
    msel_off_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bypass_w |-> !msel_mon);
endmodule

// File: tb/pswallow_div_tb.sv
module pswallow_div_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [8:0] m_val = 9'd4;
    logic [3:0] a_val = 4'd0;
    logic       presc_en_n = 1'b0;
    logic       direct_mode = 1'b0;
    logic       div_pulse, msel_mon, presc_mon;

    int total = 0;
    int bad = 0;
    longint cyc = 0;
    int prev_exp = 0;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    pswallow_div u_dut (
        .clk (clk), .rst_n (rst_n), .m_val (m_val), .a_val (a_val),
        .presc_en_n (presc_en_n), .direct_mode (direct_mode),
        .div_pulse (div_pulse), .msel_mon (msel_mon), .presc_mon (presc_mon)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int ratio(input int m, input int a, input bit byp, input bit dir);
        int me;
        me = dir ? (m % 128) : m;
        return byp ? (me + 1) : (10 * (me + 1) + a);
    endfunction

    task automatic wait_pulse(output longint c);
        do @(negedge clk); while (!div_pulse);
        c = cyc;
    endtask

    // Called at the negedge where a pulse is seen; walks one main cycle.
    task automatic walk_cycle(output int n, output int ms, output int pr, output int pu);
        n = 0; ms = 0; pr = 0; pu = 0;
        do begin
            if (msel_mon) ms++;
            if (presc_mon) pr++;
            if (div_pulse) pu++;
            n++;
            @(negedge clk);
        end while (!div_pulse);
    endtask

    // Apply a setting right after a pulse; check in-flight and next cycle.
    task automatic apply(input int m, input int a, input bit byp, input bit dir, input string tag);
        longint c0, c1;
        int n, ms, pr, pu, e, me;
        wait_pulse(c0);
        m_val = 9'(m); a_val = 4'(a); presc_en_n = byp; direct_mode = dir;
        wait_pulse(c1);
        if (prev_exp != 0)
            chk(c1 - c0 == prev_exp, "R6 in-flight cycle keeps old ratio", c1 - c0, prev_exp);
        e = ratio(m, a, byp, dir);
        me = dir ? (m % 128) : m;
        walk_cycle(n, ms, pr, pu);
        chk(n == e, tag, n, e);
        chk(ms == (byp ? 0 : 11 * a), "R4 msel high clocks", ms, byp ? 0 : 11 * a);
        chk(pr == (byp ? e : me + 1), "R7 prescaler strobes", pr, byp ? e : me + 1);
        chk(pu == 1, "R5 pulse width/count", pu, 1);
        prev_exp = e;
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        chk(!div_pulse && !msel_mon && !presc_mon, "R8 outputs low in reset",
            {div_pulse, msel_mon, presc_mon}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!div_pulse && !msel_mon && !presc_mon, "R8 outputs low after reset",
            {div_pulse, msel_mon, presc_mon}, 0);
    endtask

    task automatic t_ratio;
        for (int i = 0; i < 8; i++) begin
            int m, a;
            m = 1 + i * 13;
            a = (i * 5) % 16;
            if (a > m + 1) a = m + 1;
            apply(m, a, 1'b0, 1'b0, "R1 ratio");
        end
        apply(511, 15, 1'b0, 1'b0, "R1 ratio max M");
    endtask

    task automatic t_edges;
        apply(20, 0, 1'b0, 1'b0, "R9 A=0 all divide by 10");
        apply(3, 4, 1'b0, 1'b0, "R9 A=M+1 all divide by 11");
        apply(14, 15, 1'b0, 1'b0, "R9 A=M+1 max A");
        apply(1, 2, 1'b0, 1'b0, "R9 A=M+1 min M");
    endtask

    task automatic t_bypass;
        apply(1, 9, 1'b1, 1'b0, "R2 bypass minimum ratio 2");
        apply(7, 15, 1'b1, 1'b0, "R2 bypass ignores A");
        apply(511, 3, 1'b1, 1'b0, "R2 bypass max M");
        apply(5, 0, 1'b1, 1'b0, "R2 bypass M=5");
    endtask

    task automatic t_direct;
        apply(9'h185, 4, 1'b0, 1'b1, "R3 narrow M with prescaler");
        apply(9'h1FF, 0, 1'b1, 1'b1, "R3 narrow M in bypass");
        apply(9'h1FF, 7, 1'b0, 1'b0, "R3 full M without narrow flag");
    endtask

    task automatic t_midcycle;
        longint c0, c1;
        apply(6, 2, 1'b0, 1'b0, "R1 ratio before glitch");
        wait_pulse(c0);
        m_val = 9'd20; a_val = 4'd5; presc_en_n = 1'b1; direct_mode = 1'b1;
        repeat (3) @(negedge clk);
        m_val = 9'd6; a_val = 4'd2; presc_en_n = 1'b0; direct_mode = 1'b0;
        wait_pulse(c1);
        chk(c1 - c0 == 72, "R6 mid-cycle change ignored", c1 - c0, 72);
        wait_pulse(c0);
        chk(c0 - c1 == 72, "R6 next cycle unaffected", c0 - c1, 72);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=%0d expected=0", cyc);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_ratio();
        t_edges();
        t_bypass();
        t_direct();
        t_midcycle();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule